// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Register

This block is the digital control core of a multi-channel switch array. A host writes a serial bit stream with its own slow shift clock; the block samples that clock, the data, an active-low latch enable and an active-high clear with a fast system clock. Every rising edge of the shift clock moves the chain by one position. A parallel latch drives one control bit per channel.

While the latch enable is low, the latch passes the shift chain through to the channel outputs. While the enable is high, the latch holds, so a new pattern can be loaded without disturbing the switches. Clear empties the chain and the latch together and turns every channel off. The last stage is brought out as a serial output, so several blocks can be chained on one clock.

Top module: `ser_latch_switch`

## Requirements
- R1: On each detected rising edge of `shift_clk_i`, stage k takes the value of stage k-1, and stage 0 takes `ser_i`.
- R2: Channel k is on when `sw_o[k]` is 1 and off when it is 0. Bit k of `sw_o` comes from latch position k, and each channel is independent of the others.
- R3: While `latch_en_ni` is low and clear is low, `sw_o` follows the shift chain contents.
- R4: While `latch_en_ni` is high, `sw_o` keeps the value it had when the enable rose, whatever the shift clock and data do.
- R5: While `clr_i` is high, the chain and the latch are all zero. A shift clock rising edge seen during clear has no effect.
- R6: `ser_o` equals the last stage (stage N-1). The first bit shifted in appears there after N rising edges.
- R7: With clear low and no rising edge, the chain does not change. A steady shift clock, a falling edge or data changes alone have no effect.
- R8: After `rst_ni` is asserted, the chain and the latch are zero, so `sw_o` is 0 and `ser_o` is 0.
- R9: Every input passes through a two-flop synchronizer. A change on an input shows at the outputs no later than 4 system clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data in |
| shift_clk_i | input | 1 | Shift clock (asynchronous, rising edge active) |
| latch_en_ni | input | 1 | Latch enable, active low (low = transparent) |
| clr_i | input | 1 | Clear, active high |
| sw_o | output | N | Channel on/off control bits |
| ser_o | output | 1 | Last chain stage, for cascading |

## Verification
Random sequences mix single shifts of random bits, switches of the latch enable and rare clears. These separate transparent flow-through from holding, and show whether the latch keeps the value present when the enable rose. Directed cases load a full pattern behind a closed latch and then open it. They also walk a single 1 to the serial output, which exposes off-by-one chain length and bit-order faults. A rising shift edge is given during clear, so a design that shifts or keeps data through clear is caught. Levels held on the shift clock and its falling edges are also applied, and must leave the outputs unchanged.

// File: rtl/slsw_pkg.sv
package slsw_pkg;
  typedef struct packed {
    logic dat;
    logic sclk;
    logic le_n;
    logic clr;
  } ctl_t;
endpackage

// File: rtl/slsw_sync.sv
module slsw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/slsw_chain.sv
module slsw_chain #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         dat_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (step_i) q_o <= {q_o[N-2:0], dat_i};
  end
endmodule

// File: rtl/slsw_latch.sv
module slsw_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/ser_latch_switch.sv
module ser_latch_switch
  import slsw_pkg::*;
#(
  parameter int N        = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         shift_clk_i,
  input  logic         latch_en_ni,
  input  logic         clr_i,
  output logic [N-1:0] sw_o,
  output logic         ser_o
);
  localparam int CtlW = $bits(ctl_t);

  ctl_t raw, syn;
  logic sclk_d;
  logic shift_pulse;
  logic dat_s, le_s, clr_s;
  logic [N-1:0] sr_q;

  assign raw = '{dat: ser_i, sclk: shift_clk_i, le_n: latch_en_ni, clr: clr_i};

  slsw_sync #(.W(CtlW), .STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign dat_s = syn.dat;
  assign le_s  = syn.le_n;
  assign clr_s = syn.clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= syn.sclk;
  end

  // edge seen during clear is dropped
  assign shift_pulse = syn.sclk & ~sclk_d & ~clr_s;

  slsw_chain #(.N(N)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_s),
    .step_i(shift_pulse),
    .dat_i (dat_s),
    .q_o   (sr_q)
  );

  slsw_latch #(.N(N)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_s),
    .hold_i(le_s),
    .d_i   (sr_q),
    .q_o   (sw_o)
  );

  assign ser_o = sr_q[N-1];
endmodule

// File: rtl/ser_latch_switch_chk.sv
module ser_latch_switch_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         shift_pulse,
  input logic         dat_s,
  input logic         le_s,
  input logic         clr_s,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] sw_o
);
  a_r1_shift_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_pulse |=> sr_q == {$past(sr_q[N-2:0]), $past(dat_s)});

  a_r3_flow_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_s && !clr_s) |=> sw_o == $past(sr_q));

  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_s && !clr_s) |=> $stable(sw_o));

  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> (sw_o == '0 && sr_q == '0));

  a_r7_no_edge_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_pulse && !clr_s) |=> $stable(sr_q));
endmodule

bind ser_latch_switch ser_latch_switch_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shift_pulse(shift_pulse),
  .dat_s      (dat_s),
  .le_s       (le_s),
  .clr_s      (clr_s),
  .sr_q       (sr_q),
  .sw_o       (sw_o)
);

// File: tb/ser_latch_switch_tb.sv
module ser_latch_switch_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, sclk = 1'b0, le_n = 1'b0, clr = 1'b0;
  logic [N-1:0] sw;
  logic ser_out;

  int checks = 0, fails = 0;
  logic [N-1:0] m_sr = '0, m_lat = '0;
  logic m_le_n = 1'b0;

  always #4 clk = ~clk;

  ser_latch_switch #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .shift_clk_i(sclk),
    .latch_en_ni(le_n), .clr_i(clr), .sw_o(sw), .ser_o(ser_out)
  );

  function automatic logic [N-1:0] f_shift(logic [N-1:0] s, logic b);
    return {s[N-2:0], b};
  endfunction

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, sw, m_lat);
    chk(req, {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sr[N-1]});
  endtask

  task automatic do_shift(logic b);
    ser = b; settle();
    sclk = 1'b1; settle();
    m_sr = f_shift(m_sr, b);
    if (!m_le_n) m_lat = m_sr;
    sclk = 1'b0; settle();
  endtask

  task automatic set_le(logic v);
    le_n = v; m_le_n = v; settle();
    if (!v) m_lat = m_sr;
  endtask

  task automatic do_clear(logic with_edge);
    clr = 1'b1; settle();
    if (with_edge) begin sclk = 1'b1; settle(); sclk = 1'b0; settle(); end
    m_sr = '0; m_lat = '0;
    check_all("R5");
    clr = 1'b0; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check_all("R8");
    rst_n = 1'b1; settle();
    check_all("R8");

    // R6: single 1 walks to serial out after N edges
    do_shift(1'b1);
    for (int i = 1; i < N; i++) begin
      chk("R6", {{(N-1){1'b0}}, ser_out}, '0);
      do_shift(1'b0);
    end
    chk("R6", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, 1'b1});
    check_all("R3");

    // R4: load behind closed latch, then open it (R2 per-channel bits)
    set_le(1'b1);
    pat = 8'hA5;
    for (int i = N-1; i >= 0; i--) do_shift(pat[i]);
    check_all("R4");
    set_le(1'b0);
    chk("R2", sw, pat);

    // R7: data wiggle and steady clock levels only
    ser = ~ser; settle(); ser = ~ser; settle();
    sclk = 1'b0; settle();
    check_all("R7");

    // R5: clear with edge during it, latch closed
    set_le(1'b1);
    do_clear(1'b1);
    set_le(1'b0);
    check_all("R5");

    // R9: output within 4 clocks of enable/data
    ser = 1'b1; settle();
    sclk = 1'b1; repeat (5) @(negedge clk);
    m_sr = f_shift(m_sr, 1'b1); m_lat = m_sr;
    check_all("R9");
    sclk = 1'b0; settle();

    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op < 13)      do_shift(1'($urandom_range(0, 1)));
      else if (op < 18) set_le(~m_le_n);
      else              do_clear(1'($urandom_range(0, 1)));
      check_all(op < 13 ? "R1" : (op < 18 ? (m_le_n ? "R4" : "R3") : "R5"));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule